// File: doc/BRIEF.md
# Tape Controller Command and Status Core

This block is the host-side register and control core of a controller that serves up to eight magnetic tape drives. The host loads a command word that selects a drive and an operation, a memory address and a word count. It then issues a start pulse or a clear pulse. The block decides whether an operation may begin and keeps the busy, done and interrupt state. It also holds a small dynamic status record for each drive: rewinding, end of tape, file mark seen, beginning of tape, write locked, ready and phase-encoded mode.

Two 16-bit status words are rebuilt every cycle from three sources: the controller's latched error flags, the live record of the selected drive, and a few bits that are always forced high or low. Each word carries an error summary bit. A status-change flag is latched whenever a monitored drive bit changes state. The data path outside the block reports the end of each operation with a one-cycle completion strobe. The strobe carries error flags to merge and the new status for the drive it names.

Top module: `tape_cmd_status`

## Requirements
- R1: The command word holds the drive number in bits 2:0. The 5-bit operation code is {bit 7, 0, bits 5:3}, so bit 6 is ignored. Codes: read 0, rewind 1, controller mode 2, space forward 3, space reverse 4, write 5, write file mark 6, erase 7, read non-stop 020, unload 021, drive mode 022 (octal).
- R2: A start pulse that arrives while busy is high changes nothing.
- R3: A start on a drive that is not ready, including an offline drive, sets the illegal flag (upper bit 12), holds busy low and raises done.
- R4: Rewind and unload set the drive's rewinding bit and clear its BOT, EOF, EOT and ready bits. Busy and done are left unchanged.
- R5: Any other accepted start clears the latched error flags, sets busy and clears done. Record-motion codes (all except 2 and 022) also clear the drive's BOT, EOF, EOT and ready bits. The two mode codes leave the drive status untouched.
- R6: The completion strobe ORs its flags into the error register and loads op_stat into the drive named by op_unit. The op_stat bit order is [6] rewinding, [5] EOT, [4] EOF, [3] BOT, [2] write lock, [1] ready, [0] PE. The strobe then clears busy and sets done, unless that drive was rewinding, in which case busy and done are untouched.
- R7: The upper word has bit 15 as its error summary, followed by data late 14, rewinding 13, illegal 12, high density 11, data error 10, EOT 9, EOF 8, BOT 7, nine track 6, bad tape 5, change 3, write lock 2, odd 1 and ready 0. Bit 15 is set when any of bits 14, 12, 10, 9, 8, 7, 5 or 1 is set. Bits 11 and 6 read 1 and bit 4 reads 0.
- R8: The lower word has bit 15 as its error summary, set when any of bits 13, 11, 6, 5, 4 or 2 is set. Bit 12 reads 0 and bit 0 is the selected drive's PE bit.
- R9: A change in a drive's rewinding, BOT, write-lock, ready or PE bit sets the change flag (upper bit 3). A change in EOF or EOT alone does not set it.
- R10: An offline drive holds and reports all-zero drive status.
- R11: A clear pulse returns the active, non-rewinding drive to ready. It also clears busy, done, the command register and the error register.
- R12: A word-count write stores bit 14 of the data into bit 15. The address register keeps only its low AW bits.
- R13: irq is done AND NOT int_disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Host write data |
| cmd_wr | input | 1 | Load command word |
| addr_wr | input | 1 | Load address register |
| wcnt_wr | input | 1 | Load word count register |
| start_pulse | input | 1 | Start the selected operation |
| clear_pulse | input | 1 | Controller clear |
| int_disable | input | 1 | Interrupt mask |
| drv_online | input | NDRV | Drive present per drive |
| op_done | input | 1 | Operation-complete strobe |
| op_unit | input | 3 | Drive the completion applies to |
| op_stat | input | 7 | New drive status |
| op_flags_hi | input | 16 | Error flags for the upper word |
| op_flags_lo | input | 16 | Error flags for the lower word |
| cmd_q | output | 16 | Command register |
| addr_q | output | AW | Address register |
| wcnt_q | output | 16 | Word count register |
| stat_hi | output | 16 | Upper status word |
| stat_lo | output | 16 | Lower status word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default parameters: eight drives and a 15-bit address. With eight drives, the full 3-bit drive field can be exercised, including a rewinding drive, an offline drive and a drive that is unloaded while another holds the selection. The 15-bit address width makes the top bit of an address write a visible masking case. A 13-entry vector table drives completion flags through both status words. These vectors cover every summary source, the forced bits, and flags that land on dynamic bit positions and must be hidden.

// File: rtl/tape_cs_pkg.sv
package tape_cs_pkg;

   localparam int DST_W  = 7;
   localparam int UNIT_W = 3;
   localparam int CODE_W = 5;

   typedef struct packed {
      logic rew;
      logic eot;
      logic eof;
      logic bot;
      logic wlk;
      logic rdy;
      logic pem;
   } drv_stat_t;

   localparam logic [CODE_W-1:0] OP_REWIND = 5'o01;
   localparam logic [CODE_W-1:0] OP_UNLOAD = 5'o21;

   // upper word bit positions
   localparam int HI_ERR = 15;
   localparam int HI_ILL = 12;
   localparam int HI_CHG = 3;

   localparam logic [15:0] HI_SUM_MASK  = 16'h57A2;
   localparam logic [15:0] HI_DYN_MASK  = 16'h2385;
   localparam logic [15:0] HI_ONE_MASK  = 16'h0840;
   localparam logic [15:0] HI_ZERO_MASK = 16'h0010;
   localparam logic [15:0] LO_SUM_MASK  = 16'h2874;
   localparam logic [15:0] LO_DYN_MASK  = 16'h0001;
   localparam logic [15:0] LO_ZERO_MASK = 16'h1000;

   function automatic logic mon_differs(drv_stat_t a, drv_stat_t b);
      return (a.rew ^ b.rew) | (a.bot ^ b.bot) | (a.wlk ^ b.wlk) |
             (a.rdy ^ b.rdy) | (a.pem ^ b.pem);
   endfunction

   function automatic drv_stat_t strip_position(drv_stat_t s);
      drv_stat_t r;
      r     = s;
      r.bot = 1'b0;
      r.eof = 1'b0;
      r.eot = 1'b0;
      r.rdy = 1'b0;
      return r;
   endfunction

endpackage

// File: rtl/tape_cmd_decode.sv
module tape_cmd_decode
   import tape_cs_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic [CW-1:0]     cmd,
   output logic [UNIT_W-1:0] unit,
   output logic [CODE_W-1:0] code,
   output logic              is_rewind,
   output logic              is_motion
);

   if (CW < 8) begin : g_bad_cw
      $error("command word must be at least 8 bits");
   end

   logic unused_bits;
   assign unused_bits = ^{cmd[CW-1:8], cmd[6]};

   assign unit      = cmd[UNIT_W-1:0];
   assign code      = {cmd[7], 1'b0, cmd[5:3]};
   assign is_rewind = (code == OP_REWIND) || (code == OP_UNLOAD);
   // the two mode codes do not move tape
   assign is_motion = !((code[2:0] == 3'd2) || (code[4] && (code[2:1] != 2'b00)));

endmodule

// File: rtl/tape_drive_slot.sv
module tape_drive_slot
   import tape_cs_pkg::*;
#(
   parameter logic [DST_W-1:0] ATTACH_STAT = 7'b0001011
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      online,
   input  logic      upd_en,
   input  drv_stat_t upd_val,
   input  logic      set_active,
   input  logic      clr_active,
   input  logic      force_ready,
   output drv_stat_t stat_o,
   output logic      changed_o
);

   drv_stat_t st_q, st_nxt;
   logic      active_q, was_online_q;

   always_comb begin
      st_nxt = st_q;
      if (force_ready && active_q && !st_q.rew) st_nxt.rdy = 1'b1;
      else if (upd_en)                           st_nxt = upd_val;
      if (!online)            st_nxt = '0;
      else if (!was_online_q) st_nxt = drv_stat_t'(ATTACH_STAT);
   end

   assign changed_o = mon_differs(st_q, st_nxt);
   assign stat_o    = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= drv_stat_t'(ATTACH_STAT);
         active_q     <= 1'b0;
         was_online_q <= 1'b1;
      end else begin
         st_q         <= st_nxt;
         was_online_q <= online;
         if (force_ready || clr_active) active_q <= 1'b0;
         else if (set_active)           active_q <= 1'b1;
      end
   end

   // R10: a drive that was offline holds zero status
   a_r10_offline_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !online |=> (st_q == '0));

   // R11: clear brings an active, non-rewinding drive back to ready
   a_r11_clear_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (force_ready && active_q && !st_q.rew && online && was_online_q) |=> st_q.rdy);

endmodule

// File: rtl/tape_status_merge.sv
module tape_status_merge
   import tape_cs_pkg::*;
#(
   parameter int SW = 16
) (
   input  logic [SW-1:0] err_hi,
   input  logic [SW-1:0] err_lo,
   input  drv_stat_t     drv,
   output logic [SW-1:0] word_hi,
   output logic [SW-1:0] word_lo
);

   if (SW != 16) begin : g_bad_sw
      $error("status words are defined as 16 bits");
   end

   logic [15:0] drv_hi, drv_lo, base_hi, base_lo;

   always_comb begin
      drv_hi     = '0;
      drv_hi[13] = drv.rew;
      drv_hi[9]  = drv.eot;
      drv_hi[8]  = drv.eof;
      drv_hi[7]  = drv.bot;
      drv_hi[2]  = drv.wlk;
      drv_hi[0]  = drv.rdy;
      drv_lo     = '0;
      drv_lo[0]  = drv.pem;

      base_hi = (err_hi & ~(HI_DYN_MASK | HI_ZERO_MASK | 16'h8000)) | drv_hi | HI_ONE_MASK;
      base_lo = (err_lo & ~(LO_DYN_MASK | LO_ZERO_MASK | 16'h8000)) | drv_lo;

      word_hi         = base_hi;
      word_hi[HI_ERR] = |(base_hi & HI_SUM_MASK);
      word_lo         = base_lo;
      word_lo[15]     = |(base_lo & LO_SUM_MASK);
   end

endmodule

// File: rtl/tape_cmd_status.sv
module tape_cmd_status
   import tape_cs_pkg::*;
#(
   parameter int               NDRV        = 8,
   parameter int               AW          = 15,
   parameter int               DW          = 16,
   parameter logic [DST_W-1:0] ATTACH_STAT = 7'b0001011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       wr_data,
   input  logic              cmd_wr,
   input  logic              addr_wr,
   input  logic              wcnt_wr,
   input  logic              start_pulse,
   input  logic              clear_pulse,
   input  logic              int_disable,
   input  logic [NDRV-1:0]   drv_online,
   input  logic              op_done,
   input  logic [2:0]        op_unit,
   input  logic [6:0]        op_stat,
   input  logic [15:0]       op_flags_hi,
   input  logic [15:0]       op_flags_lo,
   output logic [15:0]       cmd_q,
   output logic [AW-1:0]     addr_q,
   output logic [15:0]       wcnt_q,
   output logic [15:0]       stat_hi,
   output logic [15:0]       stat_lo,
   output logic              busy,
   output logic              done,
   output logic              irq
);

   localparam int MAX_DRV = 1 << UNIT_W;

   if (NDRV < 1 || NDRV > MAX_DRV) begin : g_bad_ndrv
      $error("NDRV must lie in 1..8");
   end
   if (AW < 1 || AW > DW) begin : g_bad_aw
      $error("AW must lie in 1..DW");
   end
   if (DW != 16) begin : g_bad_dw
      $error("register width is fixed at 16");
   end

   logic [UNIT_W-1:0] sel_unit;
   logic [CODE_W-1:0] sel_code;
   logic              sel_rewind, sel_motion;

   tape_cmd_decode #(.CW(16)) u_dec (
      .cmd       (cmd_q),
      .unit      (sel_unit),
      .code      (sel_code),
      .is_rewind (sel_rewind),
      .is_motion (sel_motion)
   );

   logic unused_code;
   assign unused_code = ^sel_code;

   drv_stat_t         drv_st [NDRV];
   logic [NDRV-1:0]   drv_chg;
   drv_stat_t         sel_stat, op_prev;
   logic              sel_ok, op_ok, op_rew;
   logic              start_eff, start_nr, start_rw, start_op, op_eff;
   logic              busy_q, done_q;
   logic [15:0]       err_hi_q, err_lo_q;
   logic [15:0]       err_hi_d, err_lo_d;

   always_comb begin
      sel_ok   = (int'(sel_unit) < NDRV);
      sel_stat = '0;
      op_ok    = (int'(op_unit) < NDRV);
      op_prev  = '0;
      for (int i = 0; i < NDRV; i++) begin
         if (sel_unit == UNIT_W'(i)) sel_stat = drv_st[i];
         if (op_unit  == UNIT_W'(i)) op_prev  = drv_st[i];
      end
   end

   assign op_eff    = op_done && !clear_pulse && op_ok;
   assign op_rew    = op_eff && op_prev.rew;
   assign start_eff = start_pulse && !clear_pulse && !op_done && !busy_q;
   assign start_nr  = start_eff && !(sel_ok && sel_stat.rdy);
   assign start_rw  = start_eff && sel_ok && sel_stat.rdy && sel_rewind;
   assign start_op  = start_eff && sel_ok && sel_stat.rdy && !sel_rewind;

   for (genvar gi = 0; gi < NDRV; gi++) begin : g_drv
      logic      hit_sel, hit_op, upd_en;
      drv_stat_t upd_val;

      assign hit_sel = (sel_unit == UNIT_W'(gi));
      assign hit_op  = op_eff && (op_unit == UNIT_W'(gi));
      assign upd_en  = hit_op || (hit_sel && (start_rw || (start_op && sel_motion)));

      always_comb begin
         if (hit_op)        upd_val = drv_stat_t'(op_stat);
         else if (start_rw) begin
            upd_val     = strip_position(drv_st[gi]);
            upd_val.rew = 1'b1;
         end
         else               upd_val = strip_position(drv_st[gi]);
      end

      tape_drive_slot #(.ATTACH_STAT(ATTACH_STAT)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .online      (drv_online[gi]),
         .upd_en      (upd_en),
         .upd_val     (upd_val),
         .set_active  (hit_sel && start_op),
         .clr_active  (hit_op),
         .force_ready (clear_pulse),
         .stat_o      (drv_st[gi]),
         .changed_o   (drv_chg[gi])
      );
   end

   always_comb begin
      err_hi_d = err_hi_q;
      err_lo_d = err_lo_q;
      if (clear_pulse) begin
         err_hi_d = '0;
         err_lo_d = '0;
      end else begin
         if (start_op) begin
            err_hi_d = '0;
            err_lo_d = '0;
         end
         if (start_nr) err_hi_d[HI_ILL] = 1'b1;
         if (op_eff) begin
            err_hi_d = err_hi_d | op_flags_hi;
            err_lo_d = err_lo_d | op_flags_lo;
         end
         if (|drv_chg) err_hi_d[HI_CHG] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         addr_q   <= '0;
         wcnt_q   <= '0;
         err_hi_q <= '0;
         err_lo_q <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         err_hi_q <= err_hi_d;
         err_lo_q <= err_lo_d;
         if (wcnt_wr) wcnt_q <= {wr_data[14], wr_data[14:0]};
         if (clear_pulse) begin
            cmd_q  <= '0;
            addr_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
         end else begin
            if (cmd_wr)  cmd_q  <= wr_data;
            if (addr_wr) addr_q <= wr_data[AW-1:0];
            if ((op_eff && !op_rew) || start_nr) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else if (start_op) begin
               busy_q <= 1'b1;
               done_q <= 1'b0;
            end
         end
      end
   end

   tape_status_merge #(.SW(16)) u_merge (
      .err_hi  (err_hi_q),
      .err_lo  (err_lo_q),
      .drv     (sel_ok ? sel_stat : drv_stat_t'('0)),
      .word_hi (stat_hi),
      .word_lo (stat_lo)
   );

   assign busy = busy_q;
   assign done = done_q;
   assign irq  = done_q & ~int_disable;

   // R2: start while busy leaves busy and done as they were
   a_r2_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_pulse && !clear_pulse && !op_done) |=> (busy_q && !done_q));

   // R3: refused start ends with done and no busy
   a_r3_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_nr |=> (done_q && !busy_q && stat_hi[HI_ILL]));

   // R4: rewind start leaves busy and done alone
   a_r4_rewind_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_rw |=> ($stable(busy_q) && $stable(done_q)));

   // R5: busy and done are never both high
   a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q));

   // R11: clear empties command, busy, done and error flags
   a_r11_clear_regs: assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse |=> (cmd_q == '0 && !busy_q && !done_q && err_hi_q == '0 && err_lo_q == '0));

   // R12: word count top bit mirrors written bit 14
   a_r12_wcount_ext: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_wr |=> (wcnt_q[15] == $past(wr_data[14])));

endmodule

// File: tb/tape_cmd_status_bench.sv
`timescale 1ns/1ps
module tape_cmd_status_bench;

   localparam int NDRV = 8;
   localparam int AW   = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       wr_data = '0;
   logic              cmd_wr = 1'b0, addr_wr = 1'b0, wcnt_wr = 1'b0;
   logic              start_pulse = 1'b0, clear_pulse = 1'b0, int_disable = 1'b0;
   logic [NDRV-1:0]   drv_online = '1;
   logic              op_done = 1'b0;
   logic [2:0]        op_unit = '0;
   logic [6:0]        op_stat = '0;
   logic [15:0]       op_flags_hi = '0, op_flags_lo = '0;
   logic [15:0]       cmd_q, wcnt_q, stat_hi, stat_lo;
   logic [AW-1:0]     addr_q;
   logic              busy, done, irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tape_cmd_status #(.NDRV(NDRV), .AW(AW)) u_tape_cmd_status (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .cmd_wr(cmd_wr),
      .addr_wr(addr_wr), .wcnt_wr(wcnt_wr), .start_pulse(start_pulse),
      .clear_pulse(clear_pulse), .int_disable(int_disable),
      .drv_online(drv_online), .op_done(op_done), .op_unit(op_unit),
      .op_stat(op_stat), .op_flags_hi(op_flags_hi), .op_flags_lo(op_flags_lo),
      .cmd_q(cmd_q), .addr_q(addr_q), .wcnt_q(wcnt_q), .stat_hi(stat_hi),
      .stat_lo(stat_lo), .busy(busy), .done(done), .irq(irq)
   );

   // {flags_hi, flags_lo, expect_hi, expect_lo} with drive 0 = ready|PE
   localparam logic [63:0] VEC [13] = '{
      64'h4000_0000_C841_0001,
      64'h0020_0000_8861_0001,
      64'h0010_0000_0841_0001,
      64'h0002_0000_8843_0001,
      64'h0000_0080_0841_0081,
      64'h0000_0010_0841_8011,
      64'h0000_1000_0841_0001,
      64'h0000_2000_0841_A001,
      64'h2000_0001_0841_0001,
      64'h0000_0004_0841_8005,
      64'h0400_0000_8C41_0001,
      64'h8000_8000_0841_0001,
      64'h0000_0000_0841_0001
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_cmd(input logic [15:0] v);
      wr_data = v; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
   endtask

   task automatic do_start();
      start_pulse = 1'b1;
      @(negedge clk); start_pulse = 1'b0;
   endtask

   task automatic do_clear();
      clear_pulse = 1'b1;
      @(negedge clk); clear_pulse = 1'b0;
   endtask

   task automatic complete(input logic [2:0] u, input logic [6:0] s,
                           input logic [15:0] fh, input logic [15:0] fl);
      op_unit = u; op_stat = s; op_flags_hi = fh; op_flags_lo = fl; op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0; op_flags_hi = '0; op_flags_lo = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state, R7/R8 with drive 0 at ready|BOT|PE
      chk("reset busy", busy, 0);
      chk("reset done", done, 0);
      chk("R13 reset irq", irq, 0);
      chk("R7 reset hi", stat_hi, 16'h88C1);
      chk("R8 reset lo", stat_lo, 16'h0001);

      // setup: controller-mode command, drive 0 -> ready|PE
      wr_cmd(16'h0010);
      do_start();
      complete(3'd0, 7'h03, 16'h0, 16'h0);

      // R7 R8 vector walk
      foreach (VEC[i]) begin
         do_start();
         complete(3'd0, 7'h03, VEC[i][63:48], VEC[i][47:32]);
         chk($sformatf("R7 vec %0d hi", i), stat_hi, VEC[i][31:16]);
         chk($sformatf("R8 vec %0d lo", i), stat_lo, VEC[i][15:0]);
      end

      // R12
      wr_data = 16'hFFFF; addr_wr = 1'b1; @(negedge clk); addr_wr = 1'b0;
      chk("R12 addr mask", addr_q, 15'h7FFF);
      wr_data = 16'h4000; wcnt_wr = 1'b1; @(negedge clk); wcnt_wr = 1'b0;
      chk("R12 wcount ext 1", wcnt_q, 16'hC000);
      wr_data = 16'hBFFF; wcnt_wr = 1'b1; @(negedge clk); wcnt_wr = 1'b0;
      chk("R12 wcount ext 0", wcnt_q, 16'h3FFF);

      // R4 rewind on drive 1
      wr_cmd(16'h0009);
      do_start();
      chk("R4 rewind busy", busy, 0);
      chk("R4 rewind done kept", done, 1);
      chk("R4 R9 rewind hi", stat_hi, 16'h2848);

      // R3 start on not-ready drive
      do_start();
      chk("R3 not ready busy", busy, 0);
      chk("R3 not ready done", done, 1);
      chk("R3 illegal hi", stat_hi, 16'hB848);
      chk("R13 irq on", irq, 1);
      int_disable = 1'b1; #1;
      chk("R13 irq masked", irq, 0);
      int_disable = 1'b0;
      @(negedge clk);

      // R6 completion on rewinding drive leaves busy/done
      complete(3'd1, 7'h0B, 16'h0, 16'h0);
      chk("R6 rewind end done", done, 1);
      chk("R6 rewind end busy", busy, 0);
      chk("R6 rewind end hi", stat_hi, 16'h98C9);

      // R11 clear
      do_clear();
      chk("R11 clear busy", busy, 0);
      chk("R11 clear done", done, 0);
      chk("R11 clear cmd", cmd_q, 16'h0000);
      chk("R11 clear hi", stat_hi, 16'h0841);

      // R5 record motion on drive 0
      wr_cmd(16'h0000);
      do_start();
      chk("R5 read busy", busy, 1);
      chk("R5 read done", done, 0);
      chk("R5 R9 read hi", stat_hi, 16'h0848);

      // R2 start while busy ignored
      wr_cmd(16'h0008);
      do_start();
      chk("R2 busy start hi", stat_hi, 16'h0848);
      chk("R2 busy kept", busy, 1);
      wr_cmd(16'h0000);

      // R6 completion
      complete(3'd0, 7'h13, 16'h0002, 16'h0);
      chk("R6 done", done, 1);
      chk("R6 busy", busy, 0);
      chk("R6 hi", stat_hi, 16'h894B);
      chk("R6 lo", stat_lo, 16'h0001);

      // R11 clear with active drive returns it to ready
      do_start();
      chk("R11 active busy", busy, 1);
      do_clear();
      chk("R11 active ready hi", stat_hi, 16'h0841);
      chk("R11 active busy clr", busy, 0);

      // R1 R5 drive-mode code 022 keeps drive bits
      wr_cmd(16'h0090);
      do_start();
      chk("R1 R5 mode busy", busy, 1);
      chk("R5 mode hi", stat_hi, 16'h0841);
      complete(3'd0, 7'h02, 16'h0, 16'h0);
      chk("R9 PE change hi", stat_hi, 16'h0849);
      chk("R8 PE lo", stat_lo, 16'h0000);

      // R9 EOT alone is not monitored
      wr_cmd(16'h0010);
      do_start();
      complete(3'd0, 7'h22, 16'h0, 16'h0);
      chk("R9 eot no change hi", stat_hi, 16'h8A41);

      // R10 offline drive
      drv_online[2] = 1'b0;
      wr_cmd(16'h0002);
      chk("R10 offline hi", stat_hi, 16'h0848);
      chk("R10 offline lo", stat_lo, 16'h0000);
      do_start();
      chk("R3 R10 offline start hi", stat_hi, 16'h9848);
      chk("R3 R10 offline done", done, 1);

      // R1 unload with bit 6 set on drive 3
      wr_cmd(16'h00CB);
      do_start();
      chk("R1 R4 unload hi", stat_hi, 16'hB848);
      chk("R1 R4 unload busy", busy, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule